// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is the write-only control front end of a stereo audio converter. A host drives a data line, a shift clock and a latch line, all sampled in the system-clock domain. Eight bits are shifted in per word, first bit first. A rising edge on the latch line commits the word. The leading bits of the word steer it to one of three targets. The first target is the 7-bit attenuation code. The second is the playback group: de-emphasis rate, de-emphasis enable, soft mute and double speed. The third is the format group: input format and channel-clock polarity.

A static select pin picks the control source. When it is low, the serial registers are bypassed. Two pins then give the de-emphasis setting and a third, active-low pin gives double speed. The remaining controls sit at their neutral values in this mode. The outputs form a flat set of decoded control signals for the audio datapath. Serial words are still accepted while the static mode is active. They take effect when serial mode is selected again.

Top module: `ctrl3w_regs`

## Requirements
- R1: After reset, in serial mode the outputs are: attenuation code 0, de-emphasis off, rate code 2'b11 (44.1 kHz), mute off, double speed off, right-justified format (fmt_i2s = 0), and left channel on channel-clock high (lr_swap = 0).
- R2: A committed word whose first bit B0 is 0 loads att_code from B1..B7, with B1 as the MSB and B7 as the LSB. All other outputs are left unchanged.
- R3: A committed word that starts 1,0,0 (B0,B1,B2) sets deemph_rate = {B3,B4}, where 01 = 48 kHz, 10 = 32 kHz and 11 = 44.1 kHz. It also sets deemph_en = B5, soft_mute = B6 and dbl_speed = B7. The attenuation and format fields are left unchanged.
- R4: A committed word that starts 1,0,1 sets lr_swap = B6 (1 = left channel on clock low) and fmt_i2s = B7 (1 = I2S, 0 = right-justified). B3..B5 and all other outputs are unaffected.
- R5: A committed word that starts 1,1 leaves every output unchanged.
- R6: A word is committed only on a rising latch edge that follows exactly 8 rising shift-clock edges since the previous rising latch edge. A latch after 7 or 9 bits discards the word.
- R7: Shifting bits without a rising latch edge changes no output.
- R8: With pin_serial low, deemph_rate = {pin_dm1, pin_dm2} and deemph_en = pin_dm1 | pin_dm2. Both pins low means off, 10 means 32 kHz, 01 means 48 kHz and 11 means 44.1 kHz. In this mode dbl_speed = !pin_dbl_n, while att_code = 0, soft_mute = 0, fmt_i2s = 0 and lr_swap = 0.
- R9: Words committed while pin_serial is low are held. They appear on the outputs once pin_serial returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_data | input | 1 | Serial control data |
| ctl_shift | input | 1 | Serial shift clock, rising edge takes a bit |
| ctl_latch | input | 1 | Latch line, rising edge commits a word |
| pin_serial | input | 1 | 1 = serial registers drive outputs, 0 = static pins |
| pin_dm1 | input | 1 | Static de-emphasis select, high bit |
| pin_dm2 | input | 1 | Static de-emphasis select, low bit |
| pin_dbl_n | input | 1 | Static double speed, active low |
| att_code | output | 7 | Attenuation code |
| deemph_en | output | 1 | De-emphasis enable |
| deemph_rate | output | 2 | De-emphasis rate code |
| soft_mute | output | 1 | Soft mute request |
| dbl_speed | output | 1 | Double speed enable |
| fmt_i2s | output | 1 | 1 = I2S input, 0 = right-justified |
| lr_swap | output | 1 | 1 = left channel on channel-clock low |

## Verification
The assertions check several properties on every cycle. The register bank holds still in any cycle without a commit. A word with the undefined prefix leaves every field alone. Each word class touches only its own fields. The bit counter moves only on a shift edge or a latch edge, and it clears after a latch. The bench scenarios cover what needs whole transactions and the pins. These are the bit order of the attenuation code and the mode fields, the rejection of short and long words, the static-pin encodings, and the reappearance of serial settings after a spell in static mode.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
  localparam int unsigned WORD_BITS = 8;
  localparam int unsigned ATT_BITS  = WORD_BITS - 1;
  localparam logic [1:0]  RATE_44K1 = 2'b11;

  typedef enum logic [1:0] {WK_ATT, WK_MODE1, WK_MODE2, WK_BAD} word_kind_e;

  typedef struct packed {
    logic [ATT_BITS-1:0] att;
    logic                de_en;
    logic [1:0]          de_rate;
    logic                mute;
    logic                dbl;
    logic                i2s;
    logic                lr_pol;
  } ctrl_set_t;

  localparam ctrl_set_t CTRL_DEFAULT = '{att: '0, de_en: 1'b0, de_rate: RATE_44K1,
                                         mute: 1'b0, dbl: 1'b0, i2s: 1'b0, lr_pol: 1'b0};

  // word[i] holds bit Bi; B0 was shifted first
  function automatic word_kind_e classify(input logic [WORD_BITS-1:0] w);
    if (!w[0])     return WK_ATT;
    else if (w[1]) return WK_BAD;
    else if (w[2]) return WK_MODE2;
    else           return WK_MODE1;
  endfunction
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctrl3w_shifter.sv
module ctrl3w_shifter #(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 lat_s,
  input  logic                 dat_s,
  output logic [WORD_BITS-1:0] word,
  output logic                 word_valid
);
  localparam int unsigned CNT_W   = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

  logic                 sclk_q, lat_q;
  logic                 sclk_rise, lat_rise;
  logic [WORD_BITS-1:0] sr, sr_d;
  logic [CNT_W-1:0]     cnt, cnt_d;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign lat_rise  = lat_s & ~lat_q;

  always_comb begin
    sr_d  = sr;
    cnt_d = cnt;
    if (lat_rise) begin
      cnt_d = '0;
    end else if (sclk_rise) begin
      sr_d = {dat_s, sr[WORD_BITS-1:1]};
      if (cnt != CNT_OVER) cnt_d = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      lat_q  <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      lat_q  <= lat_s;
      if (sclk_rise) sr <= sr_d;
      if (sclk_rise || lat_rise) cnt <= cnt_d;
    end
  end

  assign word       = sr;
  assign word_valid = lat_rise && (cnt == CNT_FULL);

  // R6: the bit count only moves on a shift edge or a latch edge
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !lat_rise) |=> $stable(cnt));
  // R6: a latch edge starts a fresh word
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> (cnt == '0));
  // R6: the count saturates past a full word
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
endmodule

// File: rtl/ctrl3w_regs_bank.sv
module ctrl3w_regs_bank
  import ctrl3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 word_valid,
  output ctrl_set_t            cur
);
  ctrl_set_t nxt;

  always_comb begin
    nxt = cur;
    if (word_valid) begin
      unique case (classify(word))
        WK_ATT: begin
          for (int k = 0; k < ATT_BITS; k++) nxt.att[ATT_BITS-1-k] = word[k+1];
        end
        WK_MODE1: begin
          nxt.de_rate = {word[3], word[4]};
          nxt.de_en   = word[5];
          nxt.mute    = word[6];
          nxt.dbl     = word[7];
        end
        WK_MODE2: begin
          nxt.lr_pol = word[6];
          nxt.i2s    = word[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur <= CTRL_DEFAULT;
    else if (word_valid) cur <= nxt;
  end

  // R7: nothing changes without a committed word
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(cur));
  // R5: undefined prefix is ignored
  p_bad_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word[1:0] == 2'b11) |=> $stable(cur));
  // R2: attenuation word touches only the attenuation code
  p_att_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word[0]) |=> ($stable(cur.de_en) && $stable(cur.de_rate) &&
      $stable(cur.mute) && $stable(cur.dbl) && $stable(cur.i2s) && $stable(cur.lr_pol)));
  // R3: playback word leaves attenuation and format alone
  p_mode1_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word[2:0] == 3'b001) |=> ($stable(cur.att) && $stable(cur.i2s) &&
      $stable(cur.lr_pol)));
  // R4: format word leaves attenuation and playback alone
  p_mode2_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word[2:0] == 3'b101) |=> ($stable(cur.att) && $stable(cur.de_en) &&
      $stable(cur.de_rate) && $stable(cur.mute) && $stable(cur.dbl)));
endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs
  import ctrl3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_data,
  input  logic                ctl_shift,
  input  logic                ctl_latch,
  input  logic                pin_serial,
  input  logic                pin_dm1,
  input  logic                pin_dm2,
  input  logic                pin_dbl_n,
  output logic [ATT_BITS-1:0] att_code,
  output logic                deemph_en,
  output logic [1:0]          deemph_rate,
  output logic                soft_mute,
  output logic                dbl_speed,
  output logic                fmt_i2s,
  output logic                lr_swap
);
  logic                 sclk_s, lat_s, dat_s;
  logic                 serial_s, dm1_s, dm2_s, dbl_n_s;
  logic [WORD_BITS-1:0] word;
  logic                 word_valid;
  ctrl_set_t            cur, shown;

  ctrl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) i_sync_ser (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_shift, ctl_latch, ctl_data}),
    .q({sclk_s, lat_s, dat_s})
  );

  ctrl3w_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) i_sync_pin (
    .clk(clk), .rst_n(rst_n),
    .d({pin_serial, pin_dm1, pin_dm2, pin_dbl_n}),
    .q({serial_s, dm1_s, dm2_s, dbl_n_s})
  );

  ctrl3w_shifter #(.WORD_BITS(WORD_BITS)) i_shifter (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .lat_s(lat_s), .dat_s(dat_s),
    .word(word), .word_valid(word_valid)
  );

  ctrl3w_regs_bank i_bank (
    .clk(clk), .rst_n(rst_n),
    .word(word), .word_valid(word_valid),
    .cur(cur)
  );

  always_comb begin
    if (serial_s) begin
      shown = cur;
    end else begin
      shown         = CTRL_DEFAULT;
      shown.de_rate = {dm1_s, dm2_s};
      shown.de_en   = dm1_s | dm2_s;
      shown.dbl     = ~dbl_n_s;
    end
  end

  assign att_code    = shown.att;
  assign deemph_en   = shown.de_en;
  assign deemph_rate = shown.de_rate;
  assign soft_mute   = shown.mute;
  assign dbl_speed   = shown.dbl;
  assign fmt_i2s     = shown.i2s;
  assign lr_swap     = shown.lr_pol;
endmodule

// File: tb/test_ctrl3w_regs.sv
module test_ctrl3w_regs;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_data, ctl_shift, ctl_latch;
  logic pin_serial, pin_dm1, pin_dm2, pin_dbl_n;
  logic [6:0] att_code;
  logic deemph_en, soft_mute, dbl_speed, fmt_i2s, lr_swap;
  logic [1:0] deemph_rate;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [6:0] m_att;
  logic m_den, m_mute, m_dbl, m_i2s, m_pol;
  logic [1:0] m_rate;

  always #4 clk = ~clk;

  ctrl3w_regs i_ctrl3w_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_data(ctl_data), .ctl_shift(ctl_shift), .ctl_latch(ctl_latch),
    .pin_serial(pin_serial), .pin_dm1(pin_dm1), .pin_dm2(pin_dm2), .pin_dbl_n(pin_dbl_n),
    .att_code(att_code), .deemph_en(deemph_en), .deemph_rate(deemph_rate),
    .soft_mute(soft_mute), .dbl_speed(dbl_speed), .fmt_i2s(fmt_i2s), .lr_swap(lr_swap)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    chk(req, "att_code", att_code, m_att);
    chk(req, "deemph_en", deemph_en, m_den);
    chk(req, "deemph_rate", deemph_rate, m_rate);
    chk(req, "soft_mute", soft_mute, m_mute);
    chk(req, "dbl_speed", dbl_speed, m_dbl);
    chk(req, "fmt_i2s", fmt_i2s, m_i2s);
    chk(req, "lr_swap", lr_swap, m_pol);
  endtask

  task automatic shift_bits(input logic [7:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_data = w[i % 8];
      tick(3);
      ctl_shift = 1'b1;
      tick(3);
      ctl_shift = 1'b0;
      tick(3);
    end
  endtask

  task automatic pulse_latch();
    ctl_latch = 1'b1;
    tick(4);
    ctl_latch = 1'b0;
    tick(4);
  endtask

  task automatic model_apply(input logic [7:0] w);
    if (!w[0]) m_att = {w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    else if (w[1]) begin end
    else if (!w[2]) begin
      m_rate = {w[3], w[4]}; m_den = w[5]; m_mute = w[6]; m_dbl = w[7];
    end else begin
      m_pol = w[6]; m_i2s = w[7];
    end
  endtask

  function automatic logic [7:0] att_word(input logic [6:0] code);
    logic [7:0] w;
    w[0] = 1'b0;
    for (int k = 0; k < 7; k++) w[k+1] = code[6-k];
    return w;
  endfunction

  function automatic logic [7:0] mode1_word(input logic [1:0] rate, input logic en,
                                            input logic mute, input logic dbl);
    return {dbl, mute, en, rate[0], rate[1], 1'b0, 1'b0, 1'b1};
  endfunction

  function automatic string tag_of(input logic [7:0] w);
    if (!w[0]) return "R2";
    if (w[1]) return "R5";
    if (!w[2]) return "R3";
    return "R4";
  endfunction

  task automatic send(input logic [7:0] w, input int n, input string req);
    shift_bits(w, n);
    pulse_latch();
    if (n == 8) model_apply(w);
    check_model(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    rst_n = 1'b0;
    ctl_data = 1'b0; ctl_shift = 1'b0; ctl_latch = 1'b0;
    pin_serial = 1'b1; pin_dm1 = 1'b0; pin_dm2 = 1'b0; pin_dbl_n = 1'b1;
    m_att = '0; m_den = 1'b0; m_rate = 2'b11; m_mute = 1'b0; m_dbl = 1'b0;
    m_i2s = 1'b0; m_pol = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_model("R1");

    // R7: bits shifted but not latched leave outputs alone
    shift_bits(att_word(7'h55), 8);
    tick(4);
    check_model("R7");
    pulse_latch();
    model_apply(att_word(7'h55));
    check_model("R2");

    send(att_word(7'h01), 8, "R2");
    send(mode1_word(2'b10, 1'b1, 1'b1, 1'b0), 8, "R3");
    send(mode1_word(2'b01, 1'b0, 1'b0, 1'b1), 8, "R3");
    // R4: B3..B5 set in a format word have no effect on playback fields
    send(8'b1011_1101, 8, "R4");
    send(8'b0011_1101, 8, "R4");
    // R5: undefined prefix
    send(8'b1111_1111, 8, "R5");
    send(8'b0000_0011, 8, "R5");
    // R6: wrong bit counts are discarded
    send(att_word(7'h7F), 7, "R6");
    send(mode1_word(2'b11, 1'b1, 1'b1, 1'b1), 9, "R6");
    send(att_word(7'h2A), 8, "R6");

    for (int i = 0; i < 80; i++) begin
      logic [7:0] w;
      int n;
      w = 8'($urandom);
      n = 8;
      if (($urandom % 8) == 0) n = (($urandom % 2) == 0) ? 7 : 9;
      send(w, n, (n == 8) ? tag_of(w) : "R6");
    end

    // R8: static pin mode
    pin_serial = 1'b0;
    for (int c = 0; c < 8; c++) begin
      pin_dm1 = c[1]; pin_dm2 = c[0]; pin_dbl_n = c[2];
      tick(5);
      chk("R8", "deemph_rate", deemph_rate, {c[1], c[0]});
      chk("R8", "deemph_en", deemph_en, c[1] | c[0]);
      chk("R8", "dbl_speed", dbl_speed, !c[2]);
      chk("R8", "att_code", att_code, 0);
      chk("R8", "soft_mute", soft_mute, 0);
      chk("R8", "fmt_i2s", fmt_i2s, 0);
      chk("R8", "lr_swap", lr_swap, 0);
    end

    // R9: words taken in static mode show after the return to serial
    shift_bits(mode1_word(2'b01, 1'b1, 1'b1, 1'b1), 8);
    pulse_latch();
    model_apply(mode1_word(2'b01, 1'b1, 1'b1, 1'b1));
    shift_bits(8'b1100_0101, 8);
    pulse_latch();
    model_apply(8'b1100_0101);
    pin_serial = 1'b1; pin_dbl_n = 1'b1;
    tick(5);
    check_model("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule